// File: doc/BRIEF.md
# Isolated Digital I/O Register Block with Change Interrupt

This block is the device-side register set of a digital I/O card with sixteen outputs and sixteen inputs. A host reaches it over a byte-wide bus with a 3-bit address, a read strobe and a write strobe. The outputs are held in two byte latches that drive the pins and read back unchanged, so software can do read-modify-write on single bits. The inputs are synchronised, can optionally be debounced, and are read as two bytes.

Any input edge, rising or falling, is latched per byte into a status register. While interrupts are enabled, a pending flag and a level interrupt output follow. Some controls are operated by the kind of access rather than by data. A read of the interrupt-control or filter-control offset switches that function on. Any write to the same offset switches it off. A write to the low input offset clears the pending status.

Top module: `iso_io_regs`

## Requirements
- R1: After reset the output pins are 0, interrupts are disabled, filters are inactive, the status byte (offset 6) reads 0 and `irq` is low.
- R2: A write to offset 0 sets output pins 7:0 and a write to offset 4 sets output pins 15:8. A read of either offset returns the byte last written there.
- R3: Each input passes through two synchroniser flops and then an accepted-value register. A read of offset 1 returns accepted inputs 7:0 and a read of offset 5 returns accepted inputs 15:8.
- R4: A read of offset 2 enables interrupts. Any write to offset 2 disables them, whatever the data. A write takes priority over a read in the same cycle.
- R5: A read of offset 3 activates filtering on all inputs, and any write to offset 3 deactivates it. While filtering is active, a synchronised input that differs from its accepted value is accepted only after it has differed on 4 consecutive clocks. Shorter pulses are discarded.
- R6: An accepted change on inputs 7:0 sets status bit 0, and one on inputs 15:8 sets status bit 1, for either edge direction. These bits stay set until cleared, and status bits 7:3 read 0.
- R7: Status bit 2 is set one clock after status bit 0 or 1 is set while interrupts are enabled. It is held low while interrupts are disabled. `irq` always equals status bit 2.
- R8: Any write to offset 1 clears status bits 2:0 at that clock edge. An accepted change that arrives on the same edge is kept in bit 0 or 1.
- R9: Writes to offsets 5, 6 and 7 change nothing. Reads of offsets 2, 3 and 7 return 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 3 | Byte offset of the access |
| bus_rd | input | 1 | Read strobe, one clock per access |
| bus_wr | input | 1 | Write strobe, one clock per access |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr`, combinational |
| in_pins | input | 16 | Asynchronous isolated inputs |
| out_pins | output | 16 | Output latch contents |
| irq | output | 1 | Level interrupt, equal to status bit 2 |

## Verification
The assertions assume the strobes are free of X after reset and that each access lasts one clock. A held read would re-apply its side effect on every clock, which the properties treat as repeated accesses. The input pins are taken as asynchronous and need only be stable around clock edges. The stimulus drives every strobe and pin change on the falling clock edge and drops each strobe after one clock. The coincident clear-and-change case is reached by counting exactly the three register stages between a pin edge and the status latch.

// File: rtl/iso_io_pkg.sv
package iso_io_pkg;
    localparam int BYTE_W = 8;

    localparam logic [2:0] OFS_OUT_LO  = 3'd0;
    localparam logic [2:0] OFS_IN_LO   = 3'd1;
    localparam logic [2:0] OFS_IRQ_CTL = 3'd2;
    localparam logic [2:0] OFS_FLT_CTL = 3'd3;
    localparam logic [2:0] OFS_OUT_HI  = 3'd4;
    localparam logic [2:0] OFS_IN_HI   = 3'd5;
    localparam logic [2:0] OFS_STATUS  = 3'd6;

    typedef struct packed {
        logic [BYTE_W-1:0] out_lo;
        logic [BYTE_W-1:0] out_hi;
        logic              irq_en;
        logic              flt_en;
    } ctl_regs_t;
endpackage

// File: rtl/in_conditioner.sv
module in_conditioner #(
    parameter int WIDTH         = 16,
    parameter int STABLE_CYCLES = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flt_en,
    input  logic [WIDTH-1:0] pins,
    output logic [WIDTH-1:0] accepted,
    output logic [WIDTH-1:0] changed
);
    localparam int CNT_W = $clog2(STABLE_CYCLES + 1);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(STABLE_CYCLES - 1);

    typedef struct packed {
        logic [WIDTH-1:0]            s1;
        logic [WIDTH-1:0]            s2;
        logic [WIDTH-1:0]            acc;
        logic [WIDTH-1:0]            chg;
        logic [WIDTH-1:0][CNT_W-1:0] cnt;
    } cond_t;

    cond_t st_d, st_q;

    always_comb begin
        st_d    = st_q;
        st_d.s1 = pins;
        st_d.s2 = st_q.s1;
        for (int i = 0; i < WIDTH; i++) begin
            if (!flt_en) begin
                st_d.acc[i] = st_q.s2[i];
                st_d.cnt[i] = '0;
            end else if (st_q.s2[i] == st_q.acc[i]) begin
                st_d.cnt[i] = '0;
            end else if (st_q.cnt[i] == CNT_LAST) begin
                st_d.acc[i] = st_q.s2[i];
                st_d.cnt[i] = '0;
            end else begin
                st_d.cnt[i] = st_q.cnt[i] + 1'b1;
            end
        end
        st_d.chg = st_d.acc ^ st_q.acc;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign accepted = st_q.acc;
    assign changed  = st_q.chg;

    assert_unfiltered_follow_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !flt_en |=> accepted == $past(st_q.s2));

    for (genvar g = 0; g < WIDTH; g++) begin : g_hold
        assert_filter_holds_R5: assert property (@(posedge clk) disable iff (!rst_n)
            (flt_en && st_q.cnt[g] != CNT_LAST) |=> $stable(accepted[g]));
    end
endmodule

// File: rtl/irq_status_unit.sv
module irq_status_unit #(
    parameter int PORTS = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [PORTS-1:0] port_chg,
    input  logic             irq_en_next,
    input  logic             clr,
    output logic [PORTS-1:0] latched,
    output logic             pending
);
    typedef struct packed {
        logic [PORTS-1:0] lat;
        logic             pend;
    } stat_t;

    stat_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.lat  = (clr ? '0 : st_q.lat) | port_chg;
        st_d.pend = irq_en_next && !clr && (st_q.pend || (|st_q.lat));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign latched = st_q.lat;
    assign pending = st_q.pend;

    assert_latch_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && latched[0]) |=> latched[0]);

    assert_clear_keeps_change_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && port_chg[1]) |=> latched[1]);
endmodule

// File: rtl/iso_io_regs.sv
module iso_io_regs
    import iso_io_pkg::*;
#(
    parameter int STABLE_CYCLES = 4
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [2:0]  bus_addr,
    input  logic        bus_rd,
    input  logic        bus_wr,
    input  logic [7:0]  bus_wdata,
    output logic [7:0]  bus_rdata,
    input  logic [15:0] in_pins,
    output logic [15:0] out_pins,
    output logic        irq
);
    localparam int NPORT = 2;
    localparam int IN_W  = NPORT * BYTE_W;

    ctl_regs_t ctl_d, ctl_q;

    logic [IN_W-1:0]  acc_in, chg_in;
    logic [NPORT-1:0] port_chg, stat_lat;
    logic             stat_pend, clr_hit;

    in_conditioner #(.WIDTH(IN_W), .STABLE_CYCLES(STABLE_CYCLES)) u_cond (
        .clk(clk), .rst_n(rst_n), .flt_en(ctl_q.flt_en),
        .pins(in_pins), .accepted(acc_in), .changed(chg_in)
    );

    for (genvar p = 0; p < NPORT; p++) begin : g_port
        assign port_chg[p] = |chg_in[p*BYTE_W +: BYTE_W];
    end

    assign clr_hit = bus_wr && (bus_addr == OFS_IN_LO);

    always_comb begin
        ctl_d = ctl_q;
        if (bus_wr) begin
            unique case (bus_addr)
                OFS_OUT_LO:  ctl_d.out_lo = bus_wdata;
                OFS_OUT_HI:  ctl_d.out_hi = bus_wdata;
                OFS_IRQ_CTL: ctl_d.irq_en = 1'b0;
                OFS_FLT_CTL: ctl_d.flt_en = 1'b0;
                default:     ;
            endcase
        end else if (bus_rd) begin
            if (bus_addr == OFS_IRQ_CTL) ctl_d.irq_en = 1'b1;
            if (bus_addr == OFS_FLT_CTL) ctl_d.flt_en = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctl_q <= '0;
        else        ctl_q <= ctl_d;
    end

    irq_status_unit #(.PORTS(NPORT)) u_stat (
        .clk(clk), .rst_n(rst_n), .port_chg(port_chg),
        .irq_en_next(ctl_d.irq_en), .clr(clr_hit),
        .latched(stat_lat), .pending(stat_pend)
    );

    always_comb begin
        bus_rdata = '0;
        unique case (bus_addr)
            OFS_OUT_LO: bus_rdata = ctl_q.out_lo;
            OFS_OUT_HI: bus_rdata = ctl_q.out_hi;
            OFS_IN_LO:  bus_rdata = acc_in[BYTE_W-1:0];
            OFS_IN_HI:  bus_rdata = acc_in[IN_W-1:BYTE_W];
            OFS_STATUS: bus_rdata = {5'b0, stat_pend, stat_lat};
            default:    bus_rdata = '0;
        endcase
    end

    assign out_pins = {ctl_q.out_hi, ctl_q.out_lo};
    assign irq      = stat_pend;

    assert_rd_enables_irq_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && !bus_wr && bus_addr == OFS_IRQ_CTL) |=> ctl_q.irq_en);
    assert_wr_disables_irq_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == OFS_IRQ_CTL) |=> !ctl_q.irq_en);
    assert_rd_enables_filter_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && !bus_wr && bus_addr == OFS_FLT_CTL) |=> ctl_q.flt_en);
    assert_irq_needs_enable_R7: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> ctl_q.irq_en);
    assert_clear_drops_irq_R8: assert property (@(posedge clk) disable iff (!rst_n)
        clr_hit |=> !irq);
    assert_ignored_writes_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr >= OFS_IN_HI) |=> $stable(out_pins));
    assert_status_upper_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == OFS_STATUS) |-> bus_rdata[7:3] == 5'b0);
endmodule

// File: tb/iso_io_regs_test.sv
module iso_io_regs_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  bus_addr = '0;
    logic        bus_rd = 1'b0;
    logic        bus_wr = 1'b0;
    logic [7:0]  bus_wdata = '0;
    logic [7:0]  bus_rdata;
    logic [15:0] in_pins = '0;
    logic [15:0] out_pins;
    logic        irq;

    int checks = 0;
    int fails  = 0;

    always #10 clk = ~clk;

    iso_io_regs uut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_rd(bus_rd),
        .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .in_pins(in_pins), .out_pins(out_pins), .irq(irq)
    );

    // vector: {kind[1:0], req[3:0], addr[2:0], data[15:0], expect[7:0]}
    localparam logic [1:0] K_WR = 2'd0, K_RD = 2'd1, K_PIN = 2'd2;
    localparam int NVEC = 20;
    localparam logic [32:0] VEC [NVEC] = '{
        {K_WR,  4'd2, 3'd0, 16'h00A5, 8'h00},  // R2 low latch
        {K_WR,  4'd2, 3'd4, 16'h003C, 8'h00},  // R2 high latch
        {K_RD,  4'd2, 3'd0, 16'h0000, 8'hA5},  // R2 readback
        {K_RD,  4'd2, 3'd4, 16'h0000, 8'h3C},  // R2 readback
        {K_PIN, 4'd3, 3'd0, 16'h1281, 8'h00},  // R3 inputs rise
        {K_RD,  4'd3, 3'd1, 16'h0000, 8'h81},  // R3 low input byte
        {K_RD,  4'd3, 3'd5, 16'h0000, 8'h12},  // R3 high input byte
        {K_RD,  4'd6, 3'd6, 16'h0000, 8'h03},  // R6 both ports, irq off
        {K_WR,  4'd8, 3'd1, 16'h0055, 8'h00},  // R8 clear
        {K_RD,  4'd8, 3'd6, 16'h0000, 8'h00},  // R8 status cleared
        {K_WR,  4'd9, 3'd5, 16'h00FF, 8'h00},  // R9 ignored
        {K_WR,  4'd9, 3'd6, 16'h00FF, 8'h00},  // R9 ignored
        {K_WR,  4'd9, 3'd7, 16'h00FF, 8'h00},  // R9 ignored
        {K_RD,  4'd9, 3'd0, 16'h0000, 8'hA5},  // R9 latch untouched
        {K_RD,  4'd9, 3'd4, 16'h0000, 8'h3C},  // R9 latch untouched
        {K_RD,  4'd9, 3'd6, 16'h0000, 8'h00},  // R9 status untouched
        {K_RD,  4'd9, 3'd7, 16'h0000, 8'h00},  // R9 offset 7 reads 0
        {K_PIN, 4'd6, 3'd0, 16'h0281, 8'h00},  // R6 falling edge, high port
        {K_RD,  4'd6, 3'd6, 16'h0000, 8'h02},  // R6 only bit 1
        {K_WR,  4'd8, 3'd1, 16'h0000, 8'h00}   // R8 clear
    };

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [2:0] a, input logic [7:0] exp, input string req);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        #5;
        check(req, {8'h00, bus_rdata}, {8'h00, exp});
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic set_pins(input logic [15:0] v, input int settle);
        @(negedge clk);
        in_pins = v;
        repeat (settle) @(negedge clk);
    endtask

    initial begin
        #(20 * 100000);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        @(negedge clk);
        check("R1 out_pins", out_pins, 16'h0000);
        check("R1 irq", {15'b0, irq}, 16'h0000);
        bus_read(3'd6, 8'h00, "R1 status");
        bus_read(3'd0, 8'h00, "R1 out low");

        for (int i = 0; i < NVEC; i++) begin
            logic [1:0]  k;
            logic [3:0]  rq;
            logic [2:0]  a;
            logic [15:0] d;
            logic [7:0]  e;
            {k, rq, a, d, e} = VEC[i];
            case (k)
                K_WR:  bus_write(a, d[7:0]);
                K_RD:  bus_read(a, e, $sformatf("R%0d vector %0d", rq, i));
                default: set_pins(d, 6);
            endcase
        end
        check("R2 out_pins", out_pins, 16'h3CA5);

        // R4 enable by read, R9 read of 2 returns 0
        bus_read(3'd2, 8'h00, "R9 offset 2 reads 0");
        set_pins(16'h0280, 6);                      // bit 0 falls
        check("R7 irq raised", {15'b0, irq}, 16'h0001);
        bus_read(3'd6, 8'h05, "R7 status with pending");
        bus_write(3'd2, 8'hFF);                     // R4 disable
        check("R4 irq off after write", {15'b0, irq}, 16'h0000);
        bus_read(3'd6, 8'h01, "R7 pending dropped while disabled");
        bus_read(3'd2, 8'h00, "R4 re-enable");
        @(negedge clk);
        check("R7 irq re-raised", {15'b0, irq}, 16'h0001);
        bus_write(3'd1, 8'h00);
        check("R8 irq cleared", {15'b0, irq}, 16'h0000);
        bus_read(3'd6, 8'h00, "R8 status cleared");

        // R8 clear coinciding with a change
        @(negedge clk);
        in_pins = 16'h0281;
        @(negedge clk);
        @(negedge clk);
        bus_write(3'd1, 8'h00);
        bus_read(3'd6, 8'h05, "R8 coincident change kept");
        bus_write(3'd1, 8'h00);

        // R5 filter
        bus_read(3'd3, 8'h00, "R9 offset 3 reads 0");
        @(negedge clk);
        in_pins = 16'h0081;                         // 2-cycle glitch on bit 9
        @(negedge clk);
        @(negedge clk);
        in_pins = 16'h0281;
        repeat (8) @(negedge clk);
        bus_read(3'd6, 8'h00, "R5 short pulse rejected");
        bus_read(3'd5, 8'h02, "R5 accepted value unchanged");
        set_pins(16'h0081, 10);
        bus_read(3'd6, 8'h06, "R5 stable change accepted");
        bus_read(3'd5, 8'h00, "R5 accepted value");
        bus_write(3'd3, 8'h00);                     // filters off
        bus_write(3'd1, 8'h00);
        @(negedge clk);
        in_pins = 16'h0181;                         // 1-cycle glitch, unfiltered
        @(negedge clk);
        in_pins = 16'h0081;
        repeat (6) @(negedge clk);
        bus_read(3'd6, 8'h06, "R5 glitch seen with filter off");

        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule